// File: doc/BRIEF.md
# NAND Sequential Cache-Read Sequencer

This block sits on the host side of an asynchronous 8-bit NAND bus and reads a run of consecutive pages from one erase block. It uses the device's cache-read commands so that the array access for the next page overlaps with streaming the current page. After a start pulse it opens the first page with an ordinary page read and waits for the device to report ready. It then moves that page into the cache register with a continue command, which also starts the array read of the following page. The final page is moved with a distinct last command, which starts no further array read.

After each cache transfer and ready wait, the sequencer pulses the read strobe once per byte. Every byte is presented on a simple valid/data output. A page-end marker accompanies the last byte of each page, and a done flag is raised after the final byte of the run. The caller supplies the starting row, the number of pages and the number of bytes to take from each page. Row increments across the run are left to the device. Crossing an erase-block boundary and error correction are the caller's concern.

Top module: `nand_cache_reader`

## Requirements
- R1: After reset the bus is quiet (we_n=1, re_n=1, cle=0, ale=0, dq_oe=0), and out_valid, out_page_end, done and busy are all 0.
- R2: An accepted start drives these bus cycles in order: command 0x00, two column address cycles of 0x00, the starting row as three address bytes (least significant first), and command 0x30. It then waits for ready.
- R3: After that first ready, the command issued before each page is 0x31 while more than one page remains to be streamed and 0x3F for the final page. A run of N pages therefore issues exactly N-1 commands 0x31 and one 0x3F. With N=1, 0x3F follows 0x30 directly.
- R4: After each 0x30, 0x31 or 0x3F, no strobe falls until rb_n has been seen high again.
- R5: After each cache command and ready wait, exactly page_bytes read strobes are issued. Each returned byte appears once on out_data with a one-cycle out_valid, in bus order.
- R6: out_page_end is high with the last byte of every page and never without out_valid.
- R7: done rises together with the last byte of the final page. It then stays high, with busy low, until the next accepted start clears it.
- R8: A start while busy, or a start with page_count=0 or page_bytes=0, is ignored: no bus cycle, no change to the byte stream or to done.
- R9: we_n and re_n are never low together, cle and ale are never high together, and dq_oe is never high while re_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| start_row | input | ROW_W | Row address of the first page |
| page_count | input | CNT_W | Number of pages in the run |
| page_bytes | input | COL_W | Bytes taken from each page |
| busy | output | 1 | A run is in progress |
| out_valid | output | 1 | out_data holds a byte this cycle |
| out_data | output | 8 | Byte read from the device |
| out_page_end | output | 1 | Marks the last byte of a page |
| done | output | 1 | Run finished; held until next start |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven onto the bus |
| nand_dq_oe | output | 1 | Host drives the bus |
| nand_dq_in | input | 8 | Byte from the bus |
| nand_rb_n | input | 1 | Device ready (high) / busy (low) |

## Verification
The embedded properties watch, on every cycle, the bus exclusivity rules and the link between the sequencer and the bus cycle generator. They check that no request reaches the generator while it is mid-cycle and that it stays idle through every ready wait. They also check that page-end never appears without valid, and that done rises only with a page end and then holds. The order of commands and address bytes, the count of continue commands for each page count, and the byte contents and their order can be shown only by the bench's scenarios. The same holds for the hidden-versus-exposed array busy times and for ignoring mid-run or zero-length starts.

// File: rtl/nand_cr_pkg.sv
// Shared definitions for the NAND cache-read sequencer: bus cycle kinds,
// command opcodes and sequencer states. Assumes an 8-bit multiplexed bus.
package nand_cr_pkg;

    typedef enum logic [1:0] {
        BUS_CMD,
        BUS_ADDR,
        BUS_READ
    } bus_op_e;

    localparam logic [7:0] OPC_OPEN  = 8'h00;
    localparam logic [7:0] OPC_GO    = 8'h30;
    localparam logic [7:0] OPC_NEXT  = 8'h31;
    localparam logic [7:0] OPC_LAST  = 8'h3F;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_OPEN,
        SQ_ADDR,
        SQ_GO,
        SQ_SETTLE,
        SQ_READY,
        SQ_CACHE,
        SQ_STREAM
    } seq_state_e;

endpackage

// File: rtl/nand_bus_cycler.sv
// Generates one NAND bus cycle per request: a command or address write
// (we_n pulse with cle/ale) or a data read (re_n pulse, byte captured at the
// end of the low phase). Assumes req is raised only while busy is low.
module nand_bus_cycler
    import nand_cr_pkg::*;
#(
    parameter int STROBE_LO = 2,
    parameter int STROBE_HI = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  bus_op_e     op,
    input  logic [7:0]  wbyte,
    output logic        busy,
    output logic        ack,
    output logic [7:0]  rbyte,
    output logic        cle,
    output logic        ale,
    output logic        we_n,
    output logic        re_n,
    output logic [7:0]  dq_out,
    output logic        dq_oe,
    input  logic [7:0]  dq_in
);

    localparam int MAXT = (STROBE_LO > STROBE_HI) ? STROBE_LO : STROBE_HI;
    localparam int CW   = $clog2(MAXT + 1);

    logic          act_q;
    logic          hi_q;
    logic [CW-1:0] cnt_q;
    bus_op_e       op_q;
    logic [7:0]    byte_q;
    logic [7:0]    rbyte_q;

    // Phase sequencing: low strobe phase, then high recovery phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            hi_q    <= 1'b0;
            cnt_q   <= '0;
            op_q    <= BUS_CMD;
            byte_q  <= '0;
            rbyte_q <= '0;
        end else if (!act_q) begin
            if (req) begin
                act_q  <= 1'b1;
                hi_q   <= 1'b0;
                cnt_q  <= '0;
                op_q   <= op;
                byte_q <= wbyte;
            end
        end else if (!hi_q) begin
            if (cnt_q == CW'(STROBE_LO - 1)) begin
                hi_q  <= 1'b1;
                cnt_q <= '0;
                if (op_q == BUS_READ) rbyte_q <= dq_in;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == CW'(STROBE_HI - 1)) act_q <= 1'b0;
            else                             cnt_q <= cnt_q + 1'b1;
        end
    end

    // Bus pin decode from the cycle state.
    always_comb begin
        busy   = act_q;
        ack    = act_q && hi_q && (cnt_q == CW'(STROBE_HI - 1));
        rbyte  = rbyte_q;
        cle    = act_q && (op_q == BUS_CMD);
        ale    = act_q && (op_q == BUS_ADDR);
        we_n   = !(act_q && !hi_q && (op_q != BUS_READ));
        re_n   = !(act_q && !hi_q && (op_q == BUS_READ));
        dq_out = byte_q;
        dq_oe  = act_q && (op_q != BUS_READ);
    end

    // R9: strobes exclusive, no drive during a read
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    p_oe_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !dq_oe);
    p_latch_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    // R4: the sequencer never requests while a cycle is running
    p_req_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> !req);

endmodule

// File: rtl/nand_cache_seq.sv
// Command sequencer for a multi-page cache read: open page, wait ready,
// then per page a continue (or last) command, ready wait and byte stream.
// Assumes rb_n may be asynchronous (two-flop synchronised here) and that the
// device pulls rb_n low within SETTLE cycles after a busy-causing command.
module nand_cache_seq
    import nand_cr_pkg::*;
#(
    parameter int ROW_W   = 24,
    parameter int CNT_W   = 16,
    parameter int COL_W   = 12,
    parameter int COL_CYC = 2,
    parameter int SETTLE  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] start_row,
    input  logic [CNT_W-1:0] page_count,
    input  logic [COL_W-1:0] page_bytes,
    output logic             busy,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_page_end,
    output logic             done,
    input  logic             rb_n,
    output logic             bus_req,
    output bus_op_e          bus_op,
    output logic [7:0]       bus_wbyte,
    input  logic             bus_ack,
    input  logic [7:0]       bus_rbyte,
    input  logic             bus_busy
);

    localparam int ROW_CYC  = (ROW_W + 7) / 8;
    localparam int ADDR_CYC = COL_CYC + ROW_CYC;
    localparam int AW       = $clog2(ADDR_CYC + 1);
    localparam int WW       = $clog2(SETTLE + 1);

    seq_state_e       state_q;
    logic [ROW_W-1:0] row_q;
    logic [CNT_W-1:0] left_q;
    logic [COL_W-1:0] nbytes_q;
    logic [COL_W-1:0] col_q;
    logic [AW-1:0]    aidx_q;
    logic [WW-1:0]    wcnt_q;
    logic             pend_q;
    logic             from_go_q;
    logic             rb_meta_q, rb_sync_q;
    logic             valid_q, end_q, done_q;
    logic [7:0]       data_q;
    logic             issuing;
    logic [ROW_W-1:0] row_sh;

    // Ready/busy synchroniser.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_meta_q <= 1'b0;
            rb_sync_q <= 1'b0;
        end else begin
            rb_meta_q <= rb_n;
            rb_sync_q <= rb_meta_q;
        end
    end

    // Bus request decode: which cycle the current state needs.
    always_comb begin
        issuing = (state_q == SQ_OPEN) || (state_q == SQ_ADDR) ||
                  (state_q == SQ_GO)   || (state_q == SQ_CACHE) ||
                  (state_q == SQ_STREAM);
        bus_req = issuing && !pend_q;
        row_sh  = row_q >> (8 * (int'(aidx_q) - COL_CYC));
        bus_op    = BUS_CMD;
        bus_wbyte = 8'h00;
        case (state_q)
            SQ_OPEN:   bus_wbyte = OPC_OPEN;
            SQ_ADDR: begin
                bus_op    = BUS_ADDR;
                bus_wbyte = (int'(aidx_q) < COL_CYC) ? 8'h00 : row_sh[7:0];
            end
            SQ_GO:     bus_wbyte = OPC_GO;
            SQ_CACHE:  bus_wbyte = (left_q > CNT_W'(1)) ? OPC_NEXT : OPC_LAST;
            SQ_STREAM: bus_op    = BUS_READ;
            default:   bus_op    = BUS_CMD;
        endcase
    end

    // Main run control: state walk, counters and output byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            row_q     <= '0;
            left_q    <= '0;
            nbytes_q  <= '0;
            col_q     <= '0;
            aidx_q    <= '0;
            wcnt_q    <= '0;
            pend_q    <= 1'b0;
            from_go_q <= 1'b0;
            valid_q   <= 1'b0;
            end_q     <= 1'b0;
            done_q    <= 1'b0;
            data_q    <= '0;
        end else begin
            valid_q <= 1'b0;
            end_q   <= 1'b0;
            if (bus_req)      pend_q <= 1'b1;
            else if (bus_ack) pend_q <= 1'b0;
            case (state_q)
                SQ_IDLE: if (start && page_count != '0 && page_bytes != '0) begin
                    row_q    <= start_row;
                    left_q   <= page_count;
                    nbytes_q <= page_bytes;
                    aidx_q   <= '0;
                    done_q   <= 1'b0;
                    state_q  <= SQ_OPEN;
                end
                SQ_OPEN: if (bus_ack) state_q <= SQ_ADDR;
                SQ_ADDR: if (bus_ack) begin
                    if (aidx_q == AW'(ADDR_CYC - 1)) state_q <= SQ_GO;
                    else                             aidx_q  <= aidx_q + 1'b1;
                end
                SQ_GO: if (bus_ack) begin
                    from_go_q <= 1'b1;
                    wcnt_q    <= '0;
                    state_q   <= SQ_SETTLE;
                end
                SQ_SETTLE: begin
                    if (wcnt_q == WW'(SETTLE - 1)) state_q <= SQ_READY;
                    else                           wcnt_q  <= wcnt_q + 1'b1;
                end
                SQ_READY: if (rb_sync_q) begin
                    from_go_q <= 1'b0;
                    col_q     <= '0;
                    state_q   <= from_go_q ? SQ_CACHE : SQ_STREAM;
                end
                SQ_CACHE: if (bus_ack) begin
                    wcnt_q  <= '0;
                    state_q <= SQ_SETTLE;
                end
                SQ_STREAM: if (bus_ack) begin
                    valid_q <= 1'b1;
                    data_q  <= bus_rbyte;
                    if (col_q == nbytes_q - COL_W'(1)) begin
                        end_q  <= 1'b1;
                        left_q <= left_q - CNT_W'(1);
                        if (left_q == CNT_W'(1)) begin
                            done_q  <= 1'b1;
                            state_q <= SQ_IDLE;
                        end else begin
                            state_q <= SQ_CACHE;
                        end
                    end else begin
                        col_q <= col_q + COL_W'(1);
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy         = (state_q != SQ_IDLE);
    assign out_valid    = valid_q;
    assign out_data     = data_q;
    assign out_page_end = end_q;
    assign done         = done_q;

    // R6: page end only with a byte
    p_end_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_page_end |-> out_valid);
    // R7: done rises with the final page end and then holds
    p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> out_page_end);
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    // R4: bus generator idle through every ready wait
    p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_SETTLE || state_q == SQ_READY) |-> !bus_busy);
    // R1: no bus request while idle
    p_idle_noreq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

endmodule

// File: rtl/nand_cache_reader.sv
// Top of the NAND sequential cache-read block: joins the run sequencer to
// the bus cycle generator. Assumes one device on the bus, 8-bit data.
module nand_cache_reader
    import nand_cr_pkg::*;
#(
    parameter int ROW_W     = 24,
    parameter int CNT_W     = 16,
    parameter int COL_W     = 12,
    parameter int STROBE_LO = 2,
    parameter int STROBE_HI = 2,
    parameter int SETTLE    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] start_row,
    input  logic [CNT_W-1:0] page_count,
    input  logic [COL_W-1:0] page_bytes,
    output logic             busy,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_page_end,
    output logic             done,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_out,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_in,
    input  logic             nand_rb_n
);

    logic       bus_req, bus_ack, bus_busy;
    bus_op_e    bus_op;
    logic [7:0] bus_wbyte, bus_rbyte;

    nand_cache_seq #(
        .ROW_W   (ROW_W),
        .CNT_W   (CNT_W),
        .COL_W   (COL_W),
        .COL_CYC (2),
        .SETTLE  (SETTLE)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_row    (start_row),
        .page_count   (page_count),
        .page_bytes   (page_bytes),
        .busy         (busy),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_page_end (out_page_end),
        .done         (done),
        .rb_n         (nand_rb_n),
        .bus_req      (bus_req),
        .bus_op       (bus_op),
        .bus_wbyte    (bus_wbyte),
        .bus_ack      (bus_ack),
        .bus_rbyte    (bus_rbyte),
        .bus_busy     (bus_busy)
    );

    nand_bus_cycler #(
        .STROBE_LO (STROBE_LO),
        .STROBE_HI (STROBE_HI)
    ) u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .op     (bus_op),
        .wbyte  (bus_wbyte),
        .busy   (bus_busy),
        .ack    (bus_ack),
        .rbyte  (bus_rbyte),
        .cle    (nand_cle),
        .ale    (nand_ale),
        .we_n   (nand_we_n),
        .re_n   (nand_re_n),
        .dq_out (nand_dq_out),
        .dq_oe  (nand_dq_oe),
        .dq_in  (nand_dq_in)
    );

endmodule

// File: tb/tb_nand_cache_reader.sv
`timescale 1ns/1ps
module tb_nand_cache_reader;

    localparam int T_ARRAY = 60;
    localparam int T_XFER  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] start_row = '0;
    logic [15:0] page_count = '0;
    logic [11:0] page_bytes = '0;
    logic        busy, out_valid, out_page_end, done;
    logic [7:0]  out_data;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_rb_n;
    logic [7:0]  nand_dq_out, nand_dq_in;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nand_cache_reader dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_row(start_row),
        .page_count(page_count), .page_bytes(page_bytes), .busy(busy),
        .out_valid(out_valid), .out_data(out_data), .out_page_end(out_page_end),
        .done(done), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
    );

    function automatic logic [7:0] pat(input int page, input int col);
        return 8'(page * 13 + col * 7 + (col >> 3));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0] cmd_log[$];
    logic [7:0] addr_log[$];
    int  addr_cnt = 0, arr_cnt = 0, rb_cnt = 0, col_ptr = 0;
    int  data_page = 0, cache_page = 0, strobe_falls = 0;
    int  rb_viol = 0, excl_viol = 0, oe_viol = 0;
    logic [23:0] row_acc = '0;
    logic we_prev = 1'b1, re_prev = 1'b1;

    assign nand_rb_n  = (rb_cnt == 0);
    assign nand_dq_in = pat(cache_page, col_ptr);

    always @(posedge clk) begin
        we_prev <= nand_we_n;
        re_prev <= nand_re_n;
        if (arr_cnt > 0) arr_cnt <= arr_cnt - 1;
        if (rb_cnt > 0)  rb_cnt  <= rb_cnt - 1;
        if (rst_n) begin
            if ((we_prev && !nand_we_n) || (re_prev && !nand_re_n)) begin
                strobe_falls <= strobe_falls + 1;
                if (!nand_rb_n) rb_viol <= rb_viol + 1;
            end
            if (!nand_we_n && !nand_re_n) excl_viol <= excl_viol + 1;
            if (nand_cle && nand_ale)     excl_viol <= excl_viol + 1;
            if (!nand_re_n && nand_dq_oe) oe_viol <= oe_viol + 1;
            if (!we_prev && nand_we_n) begin
                if (nand_cle) begin
                    cmd_log.push_back(nand_dq_out);
                    case (nand_dq_out)
                        8'h00: addr_cnt <= 0;
                        8'h30: begin
                            data_page <= int'(row_acc);
                            arr_cnt <= T_ARRAY;
                            rb_cnt  <= T_ARRAY;
                        end
                        8'h31: begin
                            cache_page <= data_page;
                            data_page  <= data_page + 1;
                            rb_cnt  <= arr_cnt + T_XFER;
                            arr_cnt <= arr_cnt + T_XFER + T_ARRAY;
                            col_ptr <= 0;
                        end
                        8'h3F: begin
                            cache_page <= data_page;
                            rb_cnt  <= arr_cnt + T_XFER;
                            col_ptr <= 0;
                        end
                        default: ;
                    endcase
                end else if (nand_ale) begin
                    addr_log.push_back(nand_dq_out);
                    if (addr_cnt >= 2 && addr_cnt < 5)
                        row_acc[8*(addr_cnt-2) +: 8] <= nand_dq_out;
                    addr_cnt <= addr_cnt + 1;
                end
            end
            if (!re_prev && nand_re_n) col_ptr <= col_ptr + 1;
        end
    end

    // ---------------- scoreboard ----------------
    logic [8:0] exp_q[$];

    // Monitor: pop and compare each streamed byte (R5, R6).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected byte", int'(out_data), 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk(out_data == e[7:0], "R5 byte value", int'(out_data), int'(e[7:0]));
                chk(out_page_end == e[8], "R6 page end", int'(out_page_end), int'(e[8]));
            end
        end else if (rst_n && out_page_end) begin
            chk(1'b0, "R6 page end without valid", 1, 0);
        end
    end

    task automatic pulse_start(input logic [23:0] row, input int n, input int b);
        @(negedge clk);
        start_row  = row;
        page_count = 16'(n);
        page_bytes = 12'(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Driver: run one job, pushing expected bytes and checking the command trail.
    task automatic run_job(input logic [23:0] row, input int n, input int b, input bit poke);
        int cb, ab, n31;
        cb = cmd_log.size();
        ab = addr_log.size();
        for (int p = 0; p < n; p++)
            for (int c = 0; c < b; c++)
                exp_q.push_back({c == b - 1, pat(int'(row) + p, c)});
        pulse_start(row, n, b);
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        chk(done == 1'b0, "R7 done cleared by start", int'(done), 0);
        if (poke) begin
            repeat (30) @(negedge clk);
            pulse_start(row + 24'd100, 1, 2);   // R8: ignored while busy
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R7 busy low at done", int'(busy), 0);
        chk(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);
        chk(cmd_log.size() - cb == n + 2, "R3 command count", cmd_log.size() - cb, n + 2);
        chk(addr_log.size() - ab == 5, "R2 address cycles", addr_log.size() - ab, 5);
        if (cmd_log.size() - cb == n + 2 && addr_log.size() - ab == 5) begin
            chk(cmd_log[cb] == 8'h00, "R2 open opcode", cmd_log[cb], 8'h00);
            chk(cmd_log[cb+1] == 8'h30, "R2 read opcode", cmd_log[cb+1], 8'h30);
            chk(addr_log[ab] == 8'h00 && addr_log[ab+1] == 8'h00, "R2 column bytes",
                {addr_log[ab], addr_log[ab+1]}, 0);
            for (int k = 0; k < 3; k++)
                chk(addr_log[ab+2+k] == row[8*k +: 8], "R2 row byte",
                    addr_log[ab+2+k], row[8*k +: 8]);
            n31 = 0;
            for (int k = 0; k < n; k++) begin
                if (cmd_log[cb+2+k] == 8'h31) n31++;
                chk(cmd_log[cb+2+k] == ((k == n - 1) ? 8'h3F : 8'h31), "R3 cache opcode",
                    cmd_log[cb+2+k], (k == n - 1) ? 8'h3F : 8'h31);
            end
            chk(n31 == n - 1, "R3 continue count", n31, n - 1);
        end
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R7 done holds", int'(done), 1);
    endtask

    task automatic ignored_start(input int n, input int b);
        int f;
        f = strobe_falls;
        pulse_start(24'h000777, n, b);
        repeat (40) @(negedge clk);
        chk(strobe_falls == f, "R8 zero-length start no bus", strobe_falls, f);
        chk(done == 1'b1 && busy == 1'b0, "R8 zero-length start state", {done, busy}, 2'b10);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe,
            "R1 quiet bus", {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 5'b11000);
        chk(!out_valid && !out_page_end && !done && !busy, "R1 quiet outputs",
            {out_valid, out_page_end, done, busy}, 0);

        run_job(24'h000100, 1, 4, 1'b0);   // single page: 3Fh straight after 30h
        run_job(24'h123456, 3, 3, 1'b0);   // short pages: array busy exposed
        run_job(24'h00ABCD, 4, 24, 1'b0);  // long pages: array busy hidden
        run_job(24'h0000FE, 2, 1, 1'b0);   // one byte per page
        run_job(24'h040000, 3, 8, 1'b1);   // R8: start while busy
        ignored_start(0, 4);
        ignored_start(2, 0);

        chk(rb_viol == 0, "R4 strobe during busy", rb_viol, 0);
        chk(excl_viol == 0, "R9 strobe or latch overlap", excl_viol, 0);
        chk(oe_viol == 0, "R9 drive during read", oe_viol, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule